// File: doc/BRIEF.md
# Duplicate-Tag Coherence Controller

This block keeps the private L1 data caches of one to four cores coherent under a MESI protocol. It holds a shadow copy of the tag and line state of every core's data cache. When a core reports a read miss, a write miss or a write to a Shared line, the controller looks the line up in the shadow copies of all the other cores. Only the cores that really hold the line are snooped. A miss that finds a remote copy is served from that cache and not from memory. A miss that finds no copy goes to the single downstream memory port.

Requests wait in a queue with fixed priority: the lowest core index wins. The controller serves at most one request every two cycles, so requests to the same line are handled in order. Instruction fetches do not take part in coherence and go straight to memory. So does every access from a core flagged as non-coherent. The cache arrays, the instruction path and the next memory level are outside the block. The block reports the resulting line state and the data source on a response channel, and it reports the data movement on its snoop and memory outputs.

Top module: `scu_top`

## Requirements
- R1: A data read with no other coherent holder gets state Exclusive (code 2; codes are I=0, S=1, E=2, M=3) from memory. `mem_rd` pulses, no core is snooped and `resp_peer` stays 0.
- R2: A data read that finds other holders gets state Shared (code 1) with `resp_peer`=1 and no memory read. Every holder receives a demote snoop (`snp_inv`=0) and is recorded as Shared.
- R3: A data write leaves the requester Modified (code 3). Every other holder receives an invalidate snoop (`snp_inv`=1). A requester that already holds the line as Shared needs no data. A write miss takes its data from a remote holder if one exists, and from memory if none does.
- R4: When a snooped holder has the line Modified, `mem_wb` pulses in the same cycle as the response, so the line is written back as part of the intervention.
- R5: A snoop goes only to cores whose shadow entry holds the line. The requester is never snooped.
- R6: Each snoop is a single-cycle pulse. A target core is never occupied for more than 4 cycles.
- R7: An instruction request (`req_instr`=1) goes to memory with `mem_instr`=1. It returns state I, snoops no core and changes no shadow entry.
- R8: A core whose `amp_core` bit is set gets its data accesses passed to memory, and its response reports state I. It is never snooped and never counts as a holder, and its shadow entries are not updated.
- R9: At most one request is granted per two cycles, with the response one cycle after the grant. When requests arrive in the same cycle, the lowest core index is served first.
- R10: The shadow copy is direct-mapped. Address bits [5:4] select the set and bits [15:6] form the tag. A fill replaces that core's previous entry in the set.
- R11: After reset every shadow entry is Invalid and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| amp_core | input | NC | Per-core non-coherent flag |
| req_valid | input | NC | Per-core request, held until its response |
| req_write | input | NC | Request is a write (miss or upgrade) |
| req_instr | input | NC | Request is an instruction fetch |
| req_addr | input | NC*AW | Per-core request address |
| resp_valid | output | NC | One-hot response strobe |
| resp_state | output | 2 | New MESI state of the requester |
| resp_peer | output | 1 | Data is sourced from a remote cache |
| snp_valid | output | NC | Per-core snoop strobe |
| snp_inv | output | 1 | Snoop invalidates (1) or demotes to Shared (0) |
| snp_addr | output | AW | Line address of the snoop |
| mem_rd | output | 1 | Downstream line read |
| mem_wb | output | 1 | Downstream line write |
| mem_instr | output | 1 | Downstream access is an instruction fetch |
| mem_addr | output | AW | Downstream line address |

## Verification
The bench runs a sharing scenario on one line. A design that snooped every core would show extra bits in `snp_valid`. A design that forgot to demote a holder would later fill a second core in Exclusive. A design that read memory on a remote hit would raise `mem_rd` next to `resp_peer`. The bench also checks the dirty intervention for its writeback, the upgrade from Shared for the absence of data traffic, and set replacement for stale holders. Instruction and non-coherent requests are checked for leaks into the shadow state. A same-cycle conflict checks that the lower core wins and that the later reader sees the winner's Modified copy.

// File: rtl/scu_pkg.sv
package scu_pkg;
  localparam logic [1:0] ST_I = 2'd0;
  localparam logic [1:0] ST_S = 2'd1;
  localparam logic [1:0] ST_E = 2'd2;
  localparam logic [1:0] ST_M = 2'd3;

  // read fill: Shared when someone else keeps a copy, else Exclusive
  function automatic logic [1:0] read_fill(input logic others);
    return others ? ST_S : ST_E;
  endfunction

  function automatic logic is_dirty(input logic [1:0] st);
    return st == ST_M;
  endfunction
endpackage

// File: rtl/scu_arb.sv
module scu_arb #(
  parameter int NC = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] req,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx,
  output logic [NC-1:0] gnt_oh
);
  logic busy_q;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    gnt_oh    = '0;
    if (!busy_q) begin
      for (int i = NC - 1; i >= 0; i--) begin
        if (req[i]) begin
          gnt_valid = 1'b1;
          gnt_idx   = IW'(i);
        end
      end
    end
    if (gnt_valid) gnt_oh[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= gnt_valid;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_oh)); // R9
  AST_GRANT_GAP: assert property (@(posedge clk) disable iff (!rst_n) gnt_valid |=> !gnt_valid); // R9
endmodule

// File: rtl/scu_dup_tags.sv
module scu_dup_tags #(
  parameter int NC    = 4,
  parameter int SET_W = 2,
  parameter int TAG_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SET_W-1:0]      lk_set,
  input  logic [TAG_W-1:0]      lk_tag,
  output logic [NC-1:0][1:0]    lk_state,
  input  logic [NC-1:0]         wr_en,
  input  logic [NC-1:0][1:0]    wr_state
);
  import scu_pkg::*;
  localparam int SETS = 1 << SET_W;

  logic [NC-1:0] wr_m;

  for (genvar c = 0; c < NC; c++) begin : g_core
    logic [TAG_W-1:0] tag_q [SETS];
    logic [1:0]       st_q  [SETS];

    assign lk_state[c] = (tag_q[lk_set] == lk_tag) ? st_q[lk_set] : ST_I;
    assign wr_m[c]     = wr_en[c] && (wr_state[c] == ST_M);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) begin
          st_q[s]  <= ST_I;
          tag_q[s] <= '0;
        end
      end else if (wr_en[c]) begin
        st_q[lk_set]  <= wr_state[c];
        tag_q[lk_set] <= lk_tag;
      end
    end
  end

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) $countones(wr_m) <= 1); // R3
endmodule

// File: rtl/scu_top.sv
module scu_top #(
  parameter int NC    = 4,
  parameter int AW    = 16,
  parameter int OFF_W = 4,
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NC-1:0]    amp_core,
  input  logic [NC-1:0]    req_valid,
  input  logic [NC-1:0]    req_write,
  input  logic [NC-1:0]    req_instr,
  input  logic [NC*AW-1:0] req_addr,
  output logic [NC-1:0]    resp_valid,
  output logic [1:0]       resp_state,
  output logic             resp_peer,
  output logic [NC-1:0]    snp_valid,
  output logic             snp_inv,
  output logic [AW-1:0]    snp_addr,
  output logic             mem_rd,
  output logic             mem_wb,
  output logic             mem_instr,
  output logic [AW-1:0]    mem_addr
);
  import scu_pkg::*;
  localparam int TAG_W = AW - OFF_W - SET_W;
  localparam int IW    = (NC > 1) ? $clog2(NC) : 1;

  logic              gnt_valid;
  logic [IW-1:0]     gnt_idx;
  logic [NC-1:0]     gnt_oh;
  logic [AW-1:0]     r_addr;
  logic              r_wr, r_ins, r_pass;
  logic [NC-1:0][1:0] lk_state;
  logic [NC-1:0]     wr_en;
  logic [NC-1:0][1:0] wr_state;
  logic [NC-1:0]     holders;
  logic              any_holder, dirty_peer, own_valid;
  logic [1:0]        own_st;
  logic [1:0]        nx_state;
  logic              nx_peer, nx_inv, nx_rd, nx_wb;
  logic [NC-1:0]     nx_snp;

  scu_arb #(.NC(NC), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_oh(gnt_oh)
  );

  assign r_addr = req_addr[gnt_idx*AW +: AW];
  assign r_wr   = req_write[gnt_idx];
  assign r_ins  = req_instr[gnt_idx];
  assign r_pass = r_ins || amp_core[gnt_idx];

  scu_dup_tags #(.NC(NC), .SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_set(r_addr[OFF_W +: SET_W]), .lk_tag(r_addr[AW-1 -: TAG_W]),
    .lk_state(lk_state), .wr_en(wr_en), .wr_state(wr_state)
  );

  // holder filter: coherent cores other than the requester with a live copy
  always_comb begin
    dirty_peer = 1'b0;
    for (int j = 0; j < NC; j++) begin
      holders[j] = (IW'(j) != gnt_idx) && !amp_core[j] && (lk_state[j] != ST_I);
      if (holders[j] && is_dirty(lk_state[j])) dirty_peer = 1'b1;
    end
    any_holder = |holders;
    own_st     = lk_state[gnt_idx];
    own_valid  = own_st != ST_I;
  end

  always_comb begin
    nx_state = ST_I;
    nx_peer  = 1'b0;
    nx_inv   = 1'b0;
    nx_rd    = 1'b0;
    nx_wb    = 1'b0;
    nx_snp   = '0;
    wr_en    = '0;
    wr_state = '0;
    if (gnt_valid) begin
      if (r_pass) begin
        nx_rd = !r_wr;
        nx_wb = r_wr;
      end else if (!r_wr) begin
        nx_state = read_fill(any_holder);
        nx_peer  = any_holder;
        nx_rd    = !any_holder;
        nx_snp   = holders;
        nx_wb    = dirty_peer;
        for (int j = 0; j < NC; j++) begin
          wr_en[j]    = holders[j];
          wr_state[j] = ST_S;
        end
        wr_en[gnt_idx]    = 1'b1;
        wr_state[gnt_idx] = nx_state;
      end else begin
        nx_state = ST_M;
        nx_snp   = holders;
        nx_inv   = any_holder;
        nx_peer  = !own_valid && any_holder;
        nx_rd    = !own_valid && !any_holder;
        nx_wb    = dirty_peer;
        for (int j = 0; j < NC; j++) begin
          wr_en[j]    = holders[j];
          wr_state[j] = ST_I;
        end
        wr_en[gnt_idx]    = 1'b1;
        wr_state[gnt_idx] = ST_M;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= '0;
      resp_state <= ST_I;
      resp_peer  <= 1'b0;
      snp_valid  <= '0;
      snp_inv    <= 1'b0;
      snp_addr   <= '0;
      mem_rd     <= 1'b0;
      mem_wb     <= 1'b0;
      mem_instr  <= 1'b0;
      mem_addr   <= '0;
    end else begin
      resp_valid <= gnt_oh;
      resp_state <= nx_state;
      resp_peer  <= nx_peer;
      snp_valid  <= nx_snp;
      snp_inv    <= nx_inv;
      snp_addr   <= {r_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
      mem_rd     <= nx_rd;
      mem_wb     <= nx_wb;
      mem_instr  <= gnt_valid && r_ins;
      mem_addr   <= {r_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
    end
  end

  AST_REQ_NOT_SNOOPED: assert property (@(posedge clk) disable iff (!rst_n) (snp_valid & resp_valid) == '0); // R5
  AST_AMP_NOT_SNOOPED: assert property (@(posedge clk) disable iff (!rst_n) (|snp_valid) |-> (snp_valid & $past(amp_core)) == '0); // R8
  AST_PEER_NO_MEMRD: assert property (@(posedge clk) disable iff (!rst_n) resp_peer |-> !mem_rd); // R2
  AST_INSTR_NO_SNOOP: assert property (@(posedge clk) disable iff (!rst_n) mem_instr |-> snp_valid == '0); // R7
  AST_SNOOP_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n) (|snp_valid) |-> (|resp_valid)); // R5

  for (genvar c = 0; c < NC; c++) begin : g_snp_chk
    AST_SNOOP_SHORT: assert property (@(posedge clk) disable iff (!rst_n) snp_valid[c] |=> !snp_valid[c]); // R6
  end
endmodule

// File: tb/tb_scu_top.sv
module tb_scu_top;
  localparam int NC = 4;
  localparam int AW = 16;

  typedef struct packed {
    logic [1:0]  core;
    logic        wr;
    logic        ins;
    logic [15:0] addr;
    logic [3:0]  amp;
    logic [1:0]  st;
    logic        peer;
    logic [3:0]  snp;
    logic        inv;
    logic        rd;
    logic        wb;
    logic [7:0]  req;
  } vec_t;

  // addresses: A=0x0040 (set0,tag1) B=0x0050 (set1,tag1) C=0x0080 (set0,tag2)
  localparam vec_t VEC [13] = '{
    '{2'd0, 1'b0, 1'b0, 16'h0040, 4'b0000, 2'd2, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 8'd1},  // R1
    '{2'd1, 1'b0, 1'b0, 16'h0040, 4'b0000, 2'd1, 1'b1, 4'b0001, 1'b0, 1'b0, 1'b0, 8'd2},  // R2
    '{2'd2, 1'b0, 1'b0, 16'h0040, 4'b0000, 2'd1, 1'b1, 4'b0011, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 R5
    '{2'd1, 1'b1, 1'b0, 16'h0040, 4'b0000, 2'd3, 1'b0, 4'b0101, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 upgrade
    '{2'd3, 1'b0, 1'b0, 16'h0040, 4'b0000, 2'd1, 1'b1, 4'b0010, 1'b0, 1'b0, 1'b1, 8'd4},  // R4
    '{2'd0, 1'b1, 1'b0, 16'h0040, 4'b0000, 2'd3, 1'b1, 4'b1010, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 write miss, peer
    '{2'd2, 1'b1, 1'b0, 16'h0050, 4'b0000, 2'd3, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 8'd3},  // R3 write miss, memory
    '{2'd3, 1'b0, 1'b1, 16'h0040, 4'b0000, 2'd0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 8'd7},  // R7
    '{2'd0, 1'b0, 1'b0, 16'h0080, 4'b0000, 2'd2, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 8'd10}, // R10
    '{2'd1, 1'b0, 1'b0, 16'h0040, 4'b0000, 2'd2, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 8'd10}, // R10 R7
    '{2'd2, 1'b0, 1'b0, 16'h0040, 4'b0100, 2'd0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 8'd8},  // R8
    '{2'd0, 1'b0, 1'b0, 16'h0040, 4'b0100, 2'd1, 1'b1, 4'b0010, 1'b0, 1'b0, 1'b0, 8'd8},  // R8
    '{2'd3, 1'b0, 1'b0, 16'h0050, 4'b0100, 2'd2, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 8'd8}   // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]    amp_core = '0;
  logic [NC-1:0]    req_valid = '0;
  logic [NC-1:0]    req_write = '0;
  logic [NC-1:0]    req_instr = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC-1:0]    resp_valid;
  logic [1:0]       resp_state;
  logic             resp_peer;
  logic [NC-1:0]    snp_valid;
  logic             snp_inv;
  logic [AW-1:0]    snp_addr;
  logic             mem_rd, mem_wb, mem_instr;
  logic [AW-1:0]    mem_addr;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  scu_top dut (
    .clk(clk), .rst_n(rst_n), .amp_core(amp_core),
    .req_valid(req_valid), .req_write(req_write), .req_instr(req_instr), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_state(resp_state), .resp_peer(resp_peer),
    .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_addr(snp_addr),
    .mem_rd(mem_rd), .mem_wb(mem_wb), .mem_instr(mem_instr), .mem_addr(mem_addr)
  );

  function automatic logic [15:0] observed();
    return {resp_valid, resp_state, resp_peer, snp_valid, snp_inv, mem_rd, mem_wb, mem_instr};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic post_quiet(input string tag);
    @(posedge clk);
    @(negedge clk);
    check(tag, observed(), 16'h0); // R6: snoop and response were one-cycle pulses
  endtask

  task automatic run_vec(input vec_t v);
    logic [3:0] oh;
    oh = 4'b0001 << v.core;
    @(negedge clk);
    amp_core = v.amp;
    req_valid[v.core] = 1'b1;
    req_write[v.core] = v.wr;
    req_instr[v.core] = v.ins;
    req_addr[v.core*AW +: AW] = v.addr;
    @(posedge clk);
    @(negedge clk);
    check($sformatf("R%0d", v.req), observed(),
          {oh, v.st, v.peer, v.snp, v.inv, v.rd, v.wb, v.ins});
    req_valid = '0;
    req_write = '0;
    req_instr = '0;
    post_quiet("R6");
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", {observed(), mem_addr}[31:0], 32'h0); // R11 reset outputs
    rst_n = 1'b1;

    for (int i = 0; i < 13; i++) run_vec(VEC[i]);
    amp_core = '0;

    // R9 same-cycle conflict on D=0x00C0: core1 writes, core3 reads
    @(negedge clk);
    req_valid = 4'b1010;
    req_write = 4'b0010;
    req_addr[1*AW +: AW] = 16'h00C0;
    req_addr[3*AW +: AW] = 16'h00C0;
    @(posedge clk);
    @(negedge clk);
    check("R9 first", observed(), {4'b0010, 2'd3, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0});
    check("R9 addr", {mem_addr, snp_addr}, {16'h00C0, 16'h00C0});
    req_valid[1] = 1'b0;
    req_write[1] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9 gap", observed(), 16'h0);
    @(posedge clk);
    @(negedge clk);
    // R4 R9: later reader finds the winner's Modified copy
    check("R9 second", observed(), {4'b1000, 2'd1, 1'b1, 4'b0010, 1'b0, 1'b0, 1'b1, 1'b0});
    req_valid = '0;
    post_quiet("R6");

    // R11: reset clears shadow state, so a former holder is gone
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run_vec('{2'd2, 1'b0, 1'b0, 16'h00C0, 4'b0000, 2'd2, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 8'd11});

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule